// File: doc/BRIEF.md
# Two-Port Doorbell Interrupt Register

This block holds one bit vector that two bus ports share with opposite write meanings. A local agent on the system-bus side rings the doorbell by writing ones: every written one sets the matching bit. A device on the peripheral-bus side answers. It reads the vector, then writes the same pattern back, and every written one clears the matching bit. While any bit is set, the block pulls an active-low interrupt line toward the peripheral bus. The line releases once the vector is empty again.

Both ports can read the vector at any time. Per-byte strobes limit a write to selected byte lanes. If both ports touch the same bit in one cycle, the set wins, so a fresh doorbell event is never lost. The local port also has a second address that returns a mirror of the interrupt line's state. Only one clock is assumed. Bus protocol engines and decoding beyond the select and the single local address bit belong to the surrounding logic.

Top module: `doorbell_irq`

## Requirements
- R1: A local write (loc_sel=1, loc_we=1, loc_addr=0) sets, at the next rising edge, every bit whose loc_wdata bit is 1 within the enabled byte lanes.
- R2: A peripheral write (per_sel=1, per_we=1) clears, at the next rising edge, every bit whose per_wdata bit is 1 within the enabled byte lanes.
- R3: Bits written with 0 by either port keep their value.
- R4: Strobe bit k enables bits 8k+7 down to 8k. Bits in a lane whose strobe is 0 keep their value on both ports.
- R5: When one bit is set by the local port and cleared by the peripheral port in the same cycle, it ends up set.
- R6: per_rdata always shows the current vector. loc_rdata shows the same vector when loc_addr=0. Both reads are combinational and do not depend on select or write enable.
- R7: inta_n is 0 exactly when the vector held one or more set bits in the previous cycle. It is a register output, one cycle behind the vector.
- R8: With loc_addr=1, loc_rdata returns 0 in bits 31..1 and, in bit 0, a 1 while inta_n is 0. A local write with loc_addr=1 changes nothing.
- R9: During and right after reset the vector is all zero and inta_n is 1.
- R10: A select without write enable, or a write enable without select, leaves the vector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_sel | input | 1 | Local port select |
| loc_addr | input | 1 | Local address: 0 = doorbell vector, 1 = interrupt mirror |
| loc_we | input | 1 | Local write enable |
| loc_be | input | 4 | Local byte-lane strobes |
| loc_wdata | input | 32 | Local write data, ones set bits |
| loc_rdata | output | 32 | Local read data |
| per_sel | input | 1 | Peripheral port select |
| per_we | input | 1 | Peripheral write enable |
| per_be | input | 4 | Peripheral byte-lane strobes |
| per_wdata | input | 32 | Peripheral write data, ones clear bits |
| per_rdata | output | 32 | Peripheral read data |
| inta_n | output | 1 | Active-low interrupt toward the peripheral bus |

## Verification
The assertions assume that every input is a known 0 or 1 at each rising edge and that reset is held for at least one edge. They do not assume that the two ports avoid each other: simultaneous set and clear of the same bit is legal. The stimulus drives every input from a fixed-seed random source on the falling edge, so values are always defined and steady at the rising edge. It deliberately lets both ports write in the same cycle, with strobes and data drawn independently, and it includes writes to the mirror address and half-formed writes.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

  // Local-port address decode
  typedef enum logic {
    LOC_VECTOR = 1'b0,
    LOC_MIRROR = 1'b1
  } loc_addr_e;

  // Width-independent helpers, sized through the callers' parameters
  localparam int unsigned MAX_W = 64;

  function automatic logic [MAX_W-1:0] merge_bits(
    input logic [MAX_W-1:0] cur,
    input logic [MAX_W-1:0] set_v,
    input logic [MAX_W-1:0] clr_v
  );
    // clear first, then set: a set in the same cycle wins
    return (cur & ~clr_v) | set_v;
  endfunction

endpackage

// File: rtl/doorbell_lane_mask.sv
module doorbell_lane_mask #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic [LANES-1:0]  lane_en,
  output logic [DATA_W-1:0] bit_mask
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bit_mask[g*LANE_W +: LANE_W] = {LANE_W{lane_en[g]}};
  end

  always_comb begin
    p_lane_width_r4: assert ($countones(bit_mask) == LANE_W * $countones(lane_en))
      else $error("lane mask width mismatch");
  end

endmodule

// File: rtl/doorbell_bits.sv
module doorbell_bits
  import doorbell_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_vec,
  input  logic [DATA_W-1:0] clr_vec,
  output logic [DATA_W-1:0] bits_q
);

  logic [DATA_W-1:0] bits_d;
  logic [MAX_W-1:0]  merged;

  always_comb begin
    merged = merge_bits(MAX_W'(bits_q), MAX_W'(set_vec), MAX_W'(clr_vec));
    bits_d = merged[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  // R1: every requested set is present after the edge
  p_set_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((bits_q & $past(set_vec)) == $past(set_vec)))
    else $error("set bit not stored");

  // R2: requested clears take effect unless a set collides
  p_clear_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((bits_q & $past(clr_vec & ~set_vec)) == '0))
    else $error("cleared bit still set");

  // R3: untouched bits hold
  p_untouched_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((bits_q ^ $past(bits_q)) & ~$past(set_vec | clr_vec)) == '0))
    else $error("untouched bit changed");

  // R5: collision resolves to set
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & clr_vec) != '0) |=>
      ((bits_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)))
    else $error("collision lost the set");

endmodule

// File: rtl/doorbell_irq_out.sv
module doorbell_irq_out #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bits_q,
  output logic              irq_n,
  output logic              irq_active
);

  logic any_pending;

  assign any_pending = |bits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~any_pending;
  end

  assign irq_active = ~irq_n;

  // R7: line follows the vector with one register of delay
  p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_n == ($past(bits_q) == '0)))
    else $error("interrupt line out of step");

  // R9: empty vector never leaves the line asserted two cycles on
  p_irq_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bits_q == '0) |=> irq_n)
    else $error("line held with empty vector");

endmodule

// File: rtl/doorbell_irq.sv
module doorbell_irq
  import doorbell_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_sel,
  input  logic              loc_addr,
  input  logic              loc_we,
  input  logic [LANES-1:0]  loc_be,
  input  logic [DATA_W-1:0] loc_wdata,
  output logic [DATA_W-1:0] loc_rdata,
  input  logic              per_sel,
  input  logic              per_we,
  input  logic [LANES-1:0]  per_be,
  input  logic [DATA_W-1:0] per_wdata,
  output logic [DATA_W-1:0] per_rdata,
  output logic              inta_n
);

  // named internal events
  logic              loc_vec_wr;
  logic              per_vec_wr;
  logic [DATA_W-1:0] loc_mask;
  logic [DATA_W-1:0] per_mask;
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] clr_vec;
  logic [DATA_W-1:0] bits_q;
  logic              irq_active;
  loc_addr_e         loc_space;

  assign loc_space  = loc_addr_e'(loc_addr);
  assign loc_vec_wr = loc_sel & loc_we & (loc_space == LOC_VECTOR);
  assign per_vec_wr = per_sel & per_we;

  doorbell_lane_mask #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_loc_mask (
    .lane_en (loc_be),
    .bit_mask(loc_mask)
  );

  doorbell_lane_mask #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_per_mask (
    .lane_en (per_be),
    .bit_mask(per_mask)
  );

  assign set_vec = loc_vec_wr ? (loc_wdata & loc_mask) : '0;
  assign clr_vec = per_vec_wr ? (per_wdata & per_mask) : '0;

  doorbell_bits #(.DATA_W(DATA_W)) u_bits (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(set_vec),
    .clr_vec(clr_vec),
    .bits_q (bits_q)
  );

  doorbell_irq_out #(.DATA_W(DATA_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .bits_q    (bits_q),
    .irq_n     (inta_n),
    .irq_active(irq_active)
  );

  assign per_rdata = bits_q;
  assign loc_rdata = (loc_space == LOC_MIRROR) ? DATA_W'(irq_active) : bits_q;

  // R8: a local write to the mirror address alone changes nothing
  p_mirror_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_sel && loc_we && loc_addr && !(per_sel && per_we)) |=> $stable(per_rdata))
    else $error("mirror write altered vector");

  // R10: no complete write on either port keeps the vector
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(loc_sel && loc_we) && !(per_sel && per_we)) |=> $stable(per_rdata))
    else $error("vector changed without a write");

  // R6: both views of the vector agree
  p_views_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !loc_addr |-> (loc_rdata == per_rdata))
    else $error("port views differ");

endmodule

// File: tb/doorbell_irq_bench.sv
module doorbell_irq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loc_sel = 0, loc_addr = 0, loc_we = 0;
  logic [3:0]  loc_be = 0;
  logic [31:0] loc_wdata = 0;
  logic [31:0] loc_rdata;
  logic        per_sel = 0, per_we = 0;
  logic [3:0]  per_be = 0;
  logic [31:0] per_wdata = 0;
  logic [31:0] per_rdata;
  logic        inta_n;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          finished = 0;

  logic [31:0] exp_vec  = '0;
  logic        exp_inta = 1'b1;

  always #2 clk = ~clk;  // 250 MHz

  doorbell_irq u_doorbell_irq (
    .clk(clk), .rst_n(rst_n),
    .loc_sel(loc_sel), .loc_addr(loc_addr), .loc_we(loc_we), .loc_be(loc_be),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
    .per_sel(per_sel), .per_we(per_we), .per_be(per_be),
    .per_wdata(per_wdata), .per_rdata(per_rdata),
    .inta_n(inta_n)
  );

  // bit-by-bit model of the requirements
  function automatic logic [31:0] model_next(input logic [31:0] cur);
    logic [31:0] nxt = cur;
    for (int i = 0; i < 32; i++) begin
      bit do_set = loc_sel && loc_we && !loc_addr && loc_be[i/8] && loc_wdata[i];
      bit do_clr = per_sel && per_we && per_be[i/8] && per_wdata[i];
      if (do_clr) nxt[i] = 1'b0;
      if (do_set) nxt[i] = 1'b1;
    end
    return nxt;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    loc_sel = 0; loc_we = 0; loc_addr = 0; loc_be = 4'hF; loc_wdata = 0;
    per_sel = 0; per_we = 0; per_be = 4'hF; per_wdata = 0;
  endtask

  // one clock with the inputs already driven; checks at the following falling edge
  task automatic step(input string req);
    @(posedge clk);
    exp_inta = (exp_vec == 0);
    exp_vec  = model_next(exp_vec);
    @(negedge clk);
    chk({req, " vector"}, per_rdata, exp_vec);
    chk({req, " R7 inta_n"}, {31'b0, inta_n}, {31'b0, exp_inta});
    if (loc_addr) chk({req, " R8 mirror"}, loc_rdata, {31'b0, ~exp_inta});
    else          chk({req, " R6 local view"}, loc_rdata, exp_vec);
  endtask

  initial begin
    idle();
    repeat (2) @(negedge clk);
    chk("R9 reset vector", per_rdata, 32'h0);
    chk("R9 reset inta_n", {31'b0, inta_n}, 32'h1);
    rst_n = 1'b1;
    step("R9 after reset");

    // R1 ring the doorbell
    loc_sel = 1; loc_we = 1; loc_wdata = 32'h8000_0011;
    step("R1 set");
    idle();
    step("R7 assert");
    // R8 mirror read, and write to mirror ignored
    loc_sel = 1; loc_we = 1; loc_addr = 1; loc_wdata = 32'hFFFF_FFFF;
    step("R8 mirror write");
    idle();
    // R10 half-formed writes
    loc_sel = 1; loc_wdata = 32'h0000_FF00;
    per_we = 1; per_wdata = 32'hFFFF_FFFF;
    step("R10 no write");
    idle();
    // R4 strobes on both ports
    loc_sel = 1; loc_we = 1; loc_be = 4'b0100; loc_wdata = 32'hAAAA_AAAA;
    step("R4 local lanes");
    idle();
    per_sel = 1; per_we = 1; per_be = 4'b0001; per_wdata = 32'hFFFF_FFFF;
    step("R4 peripheral lanes");
    idle();
    // R3 zero data writes
    per_sel = 1; per_we = 1; per_wdata = 32'h0;
    step("R3 zero clear");
    idle();
    // R5 collision
    loc_sel = 1; loc_we = 1; loc_wdata = 32'h0F00_0000;
    per_sel = 1; per_we = 1; per_wdata = 32'hFFFF_FFFF;
    step("R5 collision");
    idle();
    // R2 handshake: read pattern, write back
    per_sel = 1; per_we = 1; per_wdata = per_rdata;
    step("R2 write back");
    idle();
    step("R7 release");
    chk("R7 released", {31'b0, inta_n}, 32'h1);

    // random phase
    void'($urandom(32'h5EED_D00B));
    for (int k = 0; k < 400; k++) begin
      loc_sel   = ($urandom % 4) != 0;
      loc_we    = ($urandom % 3) != 0;
      loc_addr  = ($urandom % 5) == 0;
      loc_be    = 4'($urandom);
      loc_wdata = $urandom & $urandom;
      per_sel   = ($urandom % 3) != 0;
      per_we    = ($urandom % 2) != 0;
      per_be    = 4'($urandom);
      per_wdata = ((k % 7) == 0) ? per_rdata : $urandom;
      step("R1 R2 R3 R4 R5 random");
    end
    idle();
    step("final");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule